// File: doc/BRIEF.md
# GF(2^8) Column Mixing Unit

This block applies the column-mixing step of the AES round to one or more 32-bit state columns. Each column holds four bytes. Each output byte is a GF(2^8) dot product of a fixed coefficient row with all four input bytes of the same column. The row rotates one place to the right for each following output byte. The `in_inv` control bit picks the transform for each column word. When it is low, the unit applies the encryption matrix, whose row is {02, 03, 01, 01}. When it is high, it applies the decryption matrix, whose row is {0E, 0B, 0D, 09}. Both matrices are built from one shared datapath. The datapath forms three successive doublings of each input byte, reduces each doubling modulo 0x11B, and XOR-combines the multiples that each coefficient needs. The unit uses no lookup tables.

The unit is a single register stage on a valid/ready stream. A column word is accepted on a clock edge where `in_valid` and `in_ready` are both high. Its mixed result is presented on `out_col`, with `out_valid` high, from the next cycle onward. Back-pressure follows these rules. While `out_valid` is high and `out_ready` is low, the output holds still and `in_ready` is low. When the output slot is empty or is being drained in the same cycle, `in_ready` is high. The result can therefore leave on the same edge that a new word enters. The parameter `NCOL` sets how many columns are processed side by side, so NCOL=4 covers a full 128-bit state. Column 0 sits in the most significant 32 bits, and byte 0 of a column sits in bits [31:24] of that column.

Top module: `gfmc_top`

## Requirements
- R1: With `in_inv`=0, the column bytes db,13,53,45 (as word 32'hdb135345) produce 32'h8e4da1bc, and 32'hf20a225c produces 32'h9fdc589d.
- R2: With `in_inv`=1, the word 32'h8e4da1bc produces 32'hdb135345, and 32'h01000000 produces 32'h0e090d0b.
- R3: Applying the decryption transform to the result of the encryption transform returns the original column for every input word.
- R4: A word accepted on an edge appears on `out_col` with `out_valid`=1 after exactly that edge (one cycle of latency). If `out_ready` is high and no word is accepted, `out_valid` is 0 after the edge.
- R5: While `out_valid`=1 and `out_ready`=0, `out_valid` and `out_col` stay unchanged on every following edge.
- R6: `in_ready` is 0 only while `out_valid`=1 and `out_ready`=0. A held result and a new input can be exchanged on the same edge.
- R7: After reset, `out_valid`=0 and `in_ready`=1.
- R8: A column made of four identical bytes is returned unchanged by both transforms, and the all-zero column maps to zero.
- R9: Doublings that shift out a set bit are reduced by XOR with 0x1B. With `in_inv`=0, the word 32'h80000000 produces 32'h1b80809b, and 32'h01000000 produces 32'h02010103.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word is present |
| in_ready | output | 1 | Unit can accept a word on this edge |
| in_inv | input | 1 | 0 = encryption matrix, 1 = decryption matrix |
| in_col | input | 32*NCOL | Input columns, column 0 in the top 32 bits, byte 0 of each column in its top 8 bits |
| out_valid | output | 1 | Result word is present |
| out_ready | input | 1 | Consumer takes the result on this edge |
| out_col | output | 32*NCOL | Mixed columns, same layout as `in_col` |

## Verification
Draining a held result and accepting a new column can happen on the same edge. This is the case the stream logic most easily gets wrong. The bench provokes it as follows. It stalls the output with `out_ready` low and keeps a second word offered on `in_valid`. It checks that the first result holds still and that `in_ready` stays low. It then raises `out_ready` while the second word is still offered. The exchange is judged correct when, one edge later, `out_valid` is still high and `out_col` carries the mixed value of the second word. A further edge without input must then empty the slot.

// File: rtl/gfmc_pkg.sv
package gfmc_pkg;

  localparam int          BYTES_PER_COL = 4;
  localparam int          COL_W         = 8 * BYTES_PER_COL;
  localparam logic [7:0]  REDUCE_LOW    = 8'h1B;

  typedef struct packed {
    logic [7:0] x8;
    logic [7:0] x4;
    logic [7:0] x2;
    logic [7:0] x1;
  } gfmc_mult_t;

  function automatic logic [7:0] gf_double(input logic [7:0] b);
    gf_double = {b[6:0], 1'b0} ^ (b[7] ? REDUCE_LOW : 8'h00);
  endfunction

  // coefficient at rotation distance k, built from doubled multiples
  function automatic logic [7:0] gf_term(input gfmc_mult_t m, input logic inv,
                                         input logic [1:0] k);
    logic [7:0] t;
    if (!inv) begin
      case (k)
        2'd0:    t = m.x2;               // 02
        2'd1:    t = m.x2 ^ m.x1;        // 03
        default: t = m.x1;               // 01
      endcase
    end else begin
      case (k)
        2'd0:    t = m.x8 ^ m.x4 ^ m.x2; // 0E
        2'd1:    t = m.x8 ^ m.x2 ^ m.x1; // 0B
        2'd2:    t = m.x8 ^ m.x4 ^ m.x1; // 0D
        default: t = m.x8 ^ m.x1;        // 09
      endcase
    end
    gf_term = t;
  endfunction

endpackage

// File: rtl/gfmc_mults.sv
module gfmc_mults
  import gfmc_pkg::*;
(
  input  logic [7:0] b,
  output gfmc_mult_t m
);
  logic [7:0] d2, d4;

  assign d2   = gf_double(b);
  assign d4   = gf_double(d2);
  assign m.x1 = b;
  assign m.x2 = d2;
  assign m.x4 = d4;
  assign m.x8 = gf_double(d4);
endmodule

// File: rtl/gfmc_column.sv
module gfmc_column
  import gfmc_pkg::*;
(
  input  logic             inv,
  input  logic [COL_W-1:0] col_in,
  output logic [COL_W-1:0] col_out
);
  gfmc_mult_t mult [BYTES_PER_COL];

  for (genvar j = 0; j < BYTES_PER_COL; j++) begin : g_mult
    gfmc_mults u_mults (
      .b (col_in[COL_W-1-8*j -: 8]),
      .m (mult[j])
    );
  end

  for (genvar i = 0; i < BYTES_PER_COL; i++) begin : g_row
    logic [7:0] acc;
    always_comb begin
      acc = 8'h00;
      for (int j = 0; j < BYTES_PER_COL; j++) begin
        acc = acc ^ gf_term(mult[j], inv, 2'(j - i));
      end
    end
    assign col_out[COL_W-1-8*i -: 8] = acc;
  end
endmodule

// File: rtl/gfmc_top.sv
module gfmc_top
  import gfmc_pkg::*;
#(
  parameter int NCOL = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic                  in_inv,
  input  logic [COL_W*NCOL-1:0] in_col,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [COL_W*NCOL-1:0] out_col
);
  localparam int DATA_W = COL_W * NCOL;

  logic [DATA_W-1:0] mixed;
  logic [DATA_W-1:0] hold_q;
  logic              valid_q;

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    gfmc_column u_column (
      .inv     (in_inv),
      .col_in  (in_col[DATA_W-1-COL_W*c -: COL_W]),
      .col_out (mixed[DATA_W-1-COL_W*c -: COL_W])
    );
  end

  assign in_ready = !valid_q || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      hold_q  <= '0;
    end else if (in_ready) begin
      valid_q <= in_valid;
      if (in_valid) hold_q <= mixed;
    end
  end

  assign out_valid = valid_q;
  assign out_col   = hold_q;
endmodule

// File: rtl/gfmc_chk.sv
module gfmc_chk #(
  parameter int NCOL = 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic [32*NCOL-1:0]  in_col,
  input logic                out_valid,
  input logic                out_ready,
  input logic [32*NCOL-1:0]  out_col
);
  logic [31:0] top_in, top_out;
  logic        same_bytes;

  assign top_in     = in_col[32*NCOL-1 -: 32];
  assign top_out    = out_col[32*NCOL-1 -: 32];
  assign same_bytes = (top_in[31:24] == top_in[23:16]) &&
                      (top_in[23:16] == top_in[15:8])  &&
                      (top_in[15:8]  == top_in[7:0]);

  a_r4_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  a_r4_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ready && !in_valid) |=> !out_valid);

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_col)));

  a_r6_stall_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> (out_valid && !out_ready));

  a_r8_fixed_point: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && same_bytes) |=> (top_out == $past(top_in)));
endmodule

bind gfmc_top gfmc_chk #(.NCOL(NCOL)) u_gfmc_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_col    (in_col),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_col   (out_col)
);

// File: tb/gfmc_top_bench.sv
module gfmc_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;
  localparam logic [64:0] VEC [NVEC] = '{
    {1'b0, 32'hdb135345, 32'h8e4da1bc},  // R1
    {1'b0, 32'hf20a225c, 32'h9fdc589d},  // R1
    {1'b1, 32'h8e4da1bc, 32'hdb135345},  // R2
    {1'b1, 32'h01000000, 32'h0e090d0b},  // R2
    {1'b0, 32'h80000000, 32'h1b80809b},  // R9
    {1'b0, 32'h01000000, 32'h02010103},  // R9
    {1'b0, 32'hc6c6c6c6, 32'hc6c6c6c6},  // R8
    {1'b1, 32'h45454545, 32'h45454545},  // R8
    {1'b0, 32'h00000000, 32'h00000000},  // R8
    {1'b0, 32'hd4d4d4d5, 32'hd5d5d7d6}   // R1
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_inv = 1'b0;
  logic [31:0] in_col = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_col;
  int          n_checks = 0;
  int          n_fail = 0;
  logic        done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gfmc_top #(.NCOL(1)) u_gfmc_top (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_inv(in_inv), .in_col(in_col), .out_valid(out_valid),
    .out_ready(out_ready), .out_col(out_col)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one word through with out_ready high; result sampled at the next negedge
  task automatic xfer(input logic inv, input logic [31:0] col, output logic [31:0] res);
    @(negedge clk);
    in_valid = 1'b1; in_inv = inv; in_col = col;
    @(negedge clk);
    in_valid = 1'b0;
    check("R4 valid", {31'd0, out_valid}, 32'd1);
    res = out_col;
  endtask

  initial begin
    logic [31:0] r, r2, x;
    repeat (2) @(negedge clk);
    check("R7 out_valid", {31'd0, out_valid}, 32'd0);
    check("R7 in_ready", {31'd0, in_ready}, 32'd1);
    rst_n = 1'b1;

    for (int v = 0; v < NVEC; v++) begin
      xfer(VEC[v][64], VEC[v][63:32], r);
      check("R1/R2/R8/R9 vector", r, VEC[v][31:0]);
    end
    @(negedge clk);
    check("R4 drain", {31'd0, out_valid}, 32'd0);

    for (int k = 0; k < 40; k++) begin  // R3 round trip
      x = $urandom;
      xfer(1'b0, x, r);
      xfer(1'b1, r, r2);
      check("R3 roundtrip", r2, x);
    end

    // R5/R6: stall, then exchange on one edge
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_inv = 1'b0; in_col = 32'hdb135345;
    @(negedge clk);
    in_col = 32'hf20a225c;
    check("R4 stalled valid", {31'd0, out_valid}, 32'd1);
    check("R6 in_ready low", {31'd0, in_ready}, 32'd0);
    repeat (2) @(negedge clk);
    check("R5 hold data", out_col, 32'h8e4da1bc);
    check("R5 hold valid", {31'd0, out_valid}, 32'd1);
    out_ready = 1'b1;
    #1;
    check("R6 in_ready high", {31'd0, in_ready}, 32'd1);
    @(negedge clk);
    in_valid = 1'b0;
    check("R6 exchange valid", {31'd0, out_valid}, 32'd1);
    check("R6 exchange data", out_col, 32'h9fdc589d);
    @(negedge clk);
    check("R4 empty after drain", {31'd0, out_valid}, 32'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule